// File: doc/BRIEF.md
# Dual-Mode Zero-Substituting AMI Line Encoder

This block turns a serial NRZ bit stream, one bit per transmit clock, into a dual-rail bipolar signal. One rail marks positive pulses and the other marks negative pulses. Ones become marks of alternating polarity. Long runs of zeros are replaced by substitution codes that contain a deliberate bipolar violation. A run-time mode input chooses between two schemes. The three-zero scheme is used at the DS3 and STS-1 rates. The four-zero scheme (HDB3) is used at the E3 rate.

Two further controls act on the output. An encoder bypass passes an externally supplied dual-rail pair straight to the rails. An all-ones request replaces everything with a continuous alternating mark pattern. The encoder holds each bit for a fixed number of clocks, so that a full zero run has been seen before any part of it leaves the block.

Top module: `zsub_line_encoder`

## Requirements
- R1: While `rst` is high at a clock edge, both rails are low after that edge. Reset leaves the encoder treating the last pulse as negative and the pulse count since the last violation as even.
- R2: Each 1 on `din` yields one pulse on exactly one rail. Successive ordinary marks alternate polarity, and the first mark after reset is positive. A positive pulse is `pos_out`=1 and a negative pulse is `neg_out`=1.
- R3: A bit sampled at a clock edge appears on the rails 3 edges later when `hdb_mode`=0, and 4 edges later when `hdb_mode`=1.
- R4: With `hdb_mode`=0, every run of three zeros is replaced by either 00V or B0V.
- R5: With `hdb_mode`=1, every run of four zeros is replaced by either 000V or B00V.
- R6: A V pulse repeats the polarity of the pulse before it. A B pulse takes the polarity opposite to the pulse before it.
- R7: The form without B is chosen when the number of pulses sent since the last V (B pulses included) is odd. The form with B is chosen when that number is even.
- R8: With `enc_bypass`=1 and `all_ones`=0, `pos_out` and `neg_out` equal `bypass_pos` and `bypass_neg` from one edge earlier, and `din` has no effect on the rails.
- R9: With `all_ones`=1, the rails carry an alternating mark on every clock, one edge after the request. The first of these marks is opposite in polarity to the last pulse sent. The request overrides both `din` and the bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | NRZ data bit |
| hdb_mode | input | 1 | 0: three-zero substitution, 1: four-zero substitution |
| enc_bypass | input | 1 | Pass `bypass_pos`/`bypass_neg` to the rails |
| bypass_pos | input | 1 | External positive rail used in bypass |
| bypass_neg | input | 1 | External negative rail used in bypass |
| all_ones | input | 1 | Force a continuous alternating mark pattern |
| pos_out | output | 1 | Positive pulse rail |
| neg_out | output | 1 | Negative pulse rail |

## Verification
The all-ones override and the encoder bypass can be asserted in the same cycle. Only one of them may reach the rails. The bench raises both at once while driving both bypass inputs high. It then checks that the rails show single alternating marks and never the doubled bypass pattern. Zero substitution and its polarity choice are judged cycle by cycle against a bench model. The model marks whole sequences offline and applies the latency for the selected mode.

// File: rtl/zsub_line_encoder.sv
module zsub_line_encoder (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic hdb_mode,
  input  logic enc_bypass,
  input  logic bypass_pos,
  input  logic bypass_neg,
  input  logic all_ones,
  output logic pos_out,
  output logic neg_out
);
  localparam logic [1:0] S_ZERO = 2'd0;
  localparam logic [1:0] S_MARK = 2'd1;
  localparam logic [1:0] S_BPUL = 2'd2;
  localparam logic [1:0] S_VIOL = 2'd3;

  logic [3:0][1:0] pipe, pipe_nx;
  logic [1:0] tap;
  logic last_pos, odd_cnt, odd_eff, run_clear, subst;

  assign tap       = hdb_mode ? pipe[3] : pipe[2];
  assign run_clear = (pipe[0] == S_ZERO) && (pipe[1] == S_ZERO) &&
                     (!hdb_mode || pipe[2] == S_ZERO);
  assign subst     = !din && run_clear;

  always_comb begin
    case (tap)
      S_VIOL:         odd_eff = 1'b0;
      S_MARK, S_BPUL: odd_eff = !odd_cnt;
      default:        odd_eff = odd_cnt;
    endcase
  end

  always_comb begin
    pipe_nx = {pipe[2:0], din ? S_MARK : S_ZERO};
    if (subst) begin
      pipe_nx[0] = S_VIOL;
      if (!odd_eff) begin
        if (hdb_mode) pipe_nx[3] = S_BPUL;
        else          pipe_nx[2] = S_BPUL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe     <= '0;
      last_pos <= 1'b0;
      odd_cnt  <= 1'b0;
      pos_out  <= 1'b0;
      neg_out  <= 1'b0;
    end else begin
      pipe <= pipe_nx;
      if (all_ones) begin
        pos_out  <= !last_pos;
        neg_out  <= last_pos;
        last_pos <= !last_pos;
        odd_cnt  <= !odd_cnt;
      end else if (enc_bypass) begin
        pos_out <= bypass_pos;
        neg_out <= bypass_neg;
      end else begin
        odd_cnt <= odd_eff;
        case (tap)
          S_MARK, S_BPUL: begin
            pos_out  <= !last_pos;
            neg_out  <= last_pos;
            last_pos <= !last_pos;
          end
          S_VIOL: begin
            pos_out <= last_pos;
            neg_out <= !last_pos;
          end
          default: begin
            pos_out <= 1'b0;
            neg_out <= 1'b0;
          end
        endcase
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!pos_out && !neg_out));

  p_one_rail_r2: assert property (@(posedge clk) disable iff (rst)
    (pos_out && neg_out) |-> $past(enc_bypass && !all_ones));

  p_bypass_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (enc_bypass && !all_ones) |=>
      (pos_out == $past(bypass_pos) && neg_out == $past(bypass_neg)));

  p_all_ones_mark_r9: assert property (@(posedge clk) disable iff (rst)
    all_ones |=> (pos_out ^ neg_out));

  p_all_ones_alt_r9: assert property (@(posedge clk) disable iff (rst)
    (all_ones && $past(all_ones) && pos_out) |=> neg_out);
endmodule

// File: tb/sim_zsub_line_encoder.sv
module sim_zsub_line_encoder;
  logic clk = 1'b0;
  logic rst, din, hdb_mode, enc_bypass, bypass_pos, bypass_neg, all_ones;
  logic pos_out, neg_out;
  int checks = 0;
  int fails = 0;
  logic [1:0] expv [128];

  always #2.5 clk = ~clk;

  zsub_line_encoder u0 (
    .clk(clk), .rst(rst), .din(din), .hdb_mode(hdb_mode),
    .enc_bypass(enc_bypass), .bypass_pos(bypass_pos), .bypass_neg(bypass_neg),
    .all_ones(all_ones), .pos_out(pos_out), .neg_out(neg_out)
  );

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rails {pos,neg} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst = 1; din = 0; hdb_mode = mode; enc_bypass = 0;
    bypass_pos = 0; bypass_neg = 0; all_ones = 0;
    @(negedge clk);
    @(negedge clk);
    check({pos_out, neg_out}, 2'b00, "R1 reset rails low");
    rst = 0;
  endtask

  task automatic build_model(input string s, input int total, input logic mode);
    int run = mode ? 4 : 3;
    int zc = 0;
    logic lastp = 0;
    logic odd = 0;
    for (int i = 0; i < total; i++) begin
      logic b = (i < s.len()) ? (s[i] == "1") : 1'b0;
      if (b) begin
        lastp = !lastp;
        expv[i] = lastp ? 2'b10 : 2'b01;
        odd = !odd;
        zc = 0;
      end else begin
        expv[i] = 2'b00;
        zc++;
        if (zc == run) begin
          if (!odd) begin
            lastp = !lastp;
            expv[i-run+1] = lastp ? 2'b10 : 2'b01;
          end
          expv[i] = lastp ? 2'b10 : 2'b01;
          odd = 0;
          zc = 0;
        end
      end
    end
  endtask

  task automatic run_seq(input logic mode, input string s, input string req);
    int lat = mode ? 4 : 3;
    int total = s.len() + lat;
    do_reset(mode);
    build_model(s, total, mode);
    for (int j = 0; j < total; j++) begin
      din = (j < s.len()) ? (s[j] == "1") : 1'b0;
      @(negedge clk);
      if (j >= lat) check({pos_out, neg_out}, expv[j-lat], req);
      else          check({pos_out, neg_out}, 2'b00, {req, " R3 latency"});
    end
  endtask

  task automatic test_bypass;
    logic [1:0] pat [6] = '{2'b10, 2'b01, 2'b11, 2'b00, 2'b11, 2'b10};
    do_reset(0);
    enc_bypass = 1;
    for (int j = 0; j < 6; j++) begin
      {bypass_pos, bypass_neg} = pat[j];
      din = j[0];
      @(negedge clk);
      check({pos_out, neg_out}, pat[j], "R8 bypass passes external rails");
    end
    enc_bypass = 0;
  endtask

  task automatic test_all_ones(input logic with_bypass);
    logic lastp = 0;
    do_reset(1);
    enc_bypass = with_bypass;
    bypass_pos = 1; bypass_neg = 1;
    all_ones = 1;
    for (int j = 0; j < 8; j++) begin
      din = 0;
      @(negedge clk);
      lastp = !lastp;
      check({pos_out, neg_out}, lastp ? 2'b10 : 2'b01,
            with_bypass ? "R9 all-ones overrides bypass" : "R9 all-ones alternates");
    end
    all_ones = 0; enc_bypass = 0;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1; din = 0; hdb_mode = 0; enc_bypass = 0;
    bypass_pos = 0; bypass_neg = 0; all_ones = 0;
    run_seq(0, "11111101", "R2 AMI alternation");
    run_seq(1, "1011", "R2 AMI first mark positive");
    run_seq(0, "1000", "R4 R7 odd count gives 00V");
    run_seq(0, "11000", "R4 R7 even count gives B0V");
    run_seq(0, "1000000000100010100000", "R4 R6 consecutive substitutions");
    run_seq(1, "10000", "R5 R7 odd count gives 000V");
    run_seq(1, "110000", "R5 R7 even count gives B00V");
    run_seq(1, "100000000000010000100001", "R5 R6 consecutive substitutions");
    run_seq(1, "1001000100001110000", "R5 short runs untouched");
    test_bypass();
    test_all_ones(0);
    test_all_ones(1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule